// File: doc/BRIEF.md
# Supply Supervisor with Reset Stretcher and Watchdog

This block watches three synchronous conditions and turns them into the reset and watchdog outputs of a board-level supervisor. A supply-low flag comes from an external comparator. An active-low manual-reset line may come from a push button, from logic, or from the block's own watchdog output looped back outside. A watchdog kick line must keep toggling while the host is healthy. The reset output is stretched by a counter, so that every reset lasts a fixed minimum time after its cause goes away. The watchdog output falls when the kick line stops moving.

The manual-reset and kick inputs are asynchronous. Each passes through a two-stage synchroniser. The manual-reset line is then debounced. All intervals are clock-cycle counts set by parameters: the debounce window, the reset hold time (a 200 ms equivalent) and the watchdog timeout. A test setup can make them short. A watchdog timeout on its own never resets the system. A reset follows only when the board routes the watchdog output back into the manual-reset input.

Top module: `sup_reset_ctrl`

## Requirements
- R1: Reset (`rst_no` = 0) asserts on the clock edge after `supply_low_i` is sampled high. It also asserts on the edge after the debounced manual-reset level becomes low. That is 3 + DEBOUNCE_CYC edges after a stable low is driven on `mr_ni`.
- R2: `rst_no` stays 0 for every cycle in which `supply_low_i` is high.
- R3: Once every trigger has gone, `rst_no` returns to 1 exactly HOLD_CYC clock edges after the last edge that sampled a trigger. For a supply-low release, this counts from the first edge that samples `supply_low_i` low. For a manual release, this is 2 + DEBOUNCE_CYC + HOLD_CYC edges after `mr_ni` goes high.
- R4: A low pulse on `mr_ni` that lasts fewer than DEBOUNCE_CYC cycles is ignored, and `rst_no` stays 1.
- R5: `rst_o` is always the exact inverse of `rst_no`.
- R6: The watchdog counter clears on every rising and falling edge of the synchronised `kick_i`. Kicks spaced closer than WDOG_CYC cycles keep `wdog_no` at 1.
- R7: If `kick_i` holds one level, `wdog_no` drops to 0 once the count reaches WDOG_CYC. It stays 0 until a kick edge arrives, and it returns to 1 four edges after the kick is driven.
- R8: The watchdog counter is held at zero while reset is asserted. With no kicks, `wdog_no` falls WDOG_CYC + 1 edges after `rst_no` rises.
- R9: `wdog_no` is 0 from the edge after `supply_low_i` is sampled high. It returns to 1 on the first edge that samples the flag low.
- R10: A watchdog timeout leaves `rst_no` at 1. When `wdog_no` is wired to `mr_ni`, a timeout asserts reset 3 + DEBOUNCE_CYC edges after `wdog_no` falls.
- R11: A new trigger during the hold interval restarts the full HOLD_CYC count.
- R12: While `rst_ni` is low, `rst_no` = 0, `rst_o` = 1 and `wdog_no` = 1. After `rst_ni` is released with no trigger present, `rst_no` rises after HOLD_CYC edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block's logic |
| supply_low_i | input | 1 | Synchronous flag, high while the supply is below the reset threshold |
| mr_ni | input | 1 | Asynchronous active-low manual reset, debounced inside |
| kick_i | input | 1 | Asynchronous watchdog kick; either edge restarts the timeout |
| rst_no | output | 1 | Active-low stretched reset |
| rst_o | output | 1 | Active-high copy of the reset |
| wdog_no | output | 1 | Active-low watchdog output |

## Verification
The hardest state to reach is the self-sustaining loop, in which the watchdog output drives the manual-reset input. In that loop a timeout must survive the debouncer, trigger a reset, clear its own counter and release the line again. The bench has a loopback switch that routes `wdog_no` onto `mr_ni` through a continuous assignment. It then stops kicking and measures the exact edge count from the watchdog falling edge to reset assertion. A manual low that lasts one cycle less than the debounce window, and a supply retrigger in the middle of the hold interval, complete the timing corners.

// File: rtl/sup_pkg.sv
package sup_pkg;
  localparam int SYNC_DEPTH = 2;

  // bits to hold values 0..n
  function automatic int cnt_bits(int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int             W       = 2,
  parameter int             STAGES  = sup_pkg::SYNC_DEPTH,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[i] <= RST_VAL;
        else         stg_q[i] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[i] <= RST_VAL;
        else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sup_debounce.sv
module sup_debounce #(
  parameter int   CYC     = 4,
  parameter logic RST_LVL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = sup_pkg::cnt_bits(CYC);

  logic          lvl_q;
  logic [CW-1:0] cnt_q;

  // new level accepted after CYC consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= RST_LVL;
      cnt_q <= '0;
    end else if (d_i == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(CYC - 1)) begin
      lvl_q <= d_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign q_o = lvl_q;
endmodule

// File: rtl/sup_hold.sv
module sup_hold #(
  parameter int CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic active_o
);
  localparam int CW = sup_pkg::cnt_bits(CYC);

  logic [CW-1:0] cnt_q;

  // full reload on each trigger; power-on starts a full hold
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= CW'(CYC);
    else if (trig_i)       cnt_q <= CW'(CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
  parameter int CYC = 24,
  localparam int CW = sup_pkg::cnt_bits(CYC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lvl_i,
  input  logic          clr_i,
  input  logic          sup_low_i,
  output logic          wdo_no,
  output logic [CW-1:0] cnt_o
);
  logic          lvl_d_q;
  logic          kick_edge;
  logic          expired;
  logic [CW-1:0] cnt_q;
  logic          wdo_q;

  assign kick_edge = lvl_i ^ lvl_d_q;
  assign expired   = (cnt_q == CW'(CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_d_q <= 1'b0;
      cnt_q   <= '0;
      wdo_q   <= 1'b1;
    end else begin
      lvl_d_q <= lvl_i;
      if (clr_i || kick_edge) cnt_q <= '0;
      else if (!expired)      cnt_q <= cnt_q + 1'b1;
      wdo_q <= !(sup_low_i || expired);
    end
  end

  assign wdo_no = wdo_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl #(
  parameter int DEBOUNCE_CYC = 1000,
  parameter int HOLD_CYC     = 20_000_000,
  parameter int WDOG_CYC     = 160_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_low_i,
  input  logic mr_ni,
  input  logic kick_i,
  output logic rst_no,
  output logic rst_o,
  output logic wdog_no
);
  localparam int WCW = sup_pkg::cnt_bits(WDOG_CYC);

  logic [1:0]     sync_q;
  logic           mr_s;
  logic           kick_s;
  logic           mr_db;
  logic           trig;
  logic           hold_act;
  logic [WCW-1:0] wd_cnt;

  // bit0: manual reset (idle high), bit1: kick (idle low)
  sup_sync #(.W(2), .STAGES(sup_pkg::SYNC_DEPTH), .RST_VAL(2'b01)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({kick_i, mr_ni}),
    .q_o   (sync_q)
  );
  assign mr_s   = sync_q[0];
  assign kick_s = sync_q[1];

  sup_debounce #(.CYC(DEBOUNCE_CYC), .RST_LVL(1'b1)) u_db (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (mr_s),
    .q_o   (mr_db)
  );

  assign trig = supply_low_i || !mr_db;

  sup_hold #(.CYC(HOLD_CYC)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (trig),
    .active_o(hold_act)
  );

  sup_wdog #(.CYC(WDOG_CYC)) u_wdog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lvl_i    (kick_s),
    .clr_i    (hold_act),
    .sup_low_i(supply_low_i),
    .wdo_no   (wdog_no),
    .cnt_o    (wd_cnt)
  );

  assign rst_no = !hold_act;
  assign rst_o  = hold_act;
endmodule

// File: rtl/sup_reset_ctrl_chk.sv
module sup_reset_ctrl_chk #(
  parameter int WDOG_CYC = 24,
  localparam int WCW = sup_pkg::cnt_bits(WDOG_CYC)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           supply_low_i,
  input logic           mr_db,
  input logic           rst_no,
  input logic           rst_o,
  input logic           wdog_no,
  input logic [WCW-1:0] wd_cnt
);
  p_trigger_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (supply_low_i || !mr_db) |=> !rst_no);

  p_supply_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_low_i |=> (!rst_no && rst_o));

  p_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> (!$past(supply_low_i) && $past(mr_db)));

  p_inverse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o == !rst_no);

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_cnt <= WCW'(WDOG_CYC));

  p_clear_in_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_no |=> (wd_cnt == '0));

  p_wdo_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_low_i |=> !wdog_no);

  p_wdo_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(supply_low_i) |=> wdog_no);

  always @(negedge rst_ni) begin
    #1;
    p_por_r12: assert (!rst_no && rst_o && wdog_no);
  end
endmodule

bind sup_reset_ctrl sup_reset_ctrl_chk #(.WDOG_CYC(WDOG_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .supply_low_i(supply_low_i),
  .mr_db       (mr_db),
  .rst_no      (rst_no),
  .rst_o       (rst_o),
  .wdog_no     (wdog_no),
  .wd_cnt      (wd_cnt)
);

// File: tb/sup_reset_ctrl_test.sv
module sup_reset_ctrl_test;
  localparam int DB   = 4;
  localparam int HOLD = 16;
  localparam int WD   = 24;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic supply_low = 1'b0;
  logic mr_man = 1'b1;
  logic loop_en = 1'b0;
  logic kick = 1'b0;
  logic mr_n;
  logic rst_no, rst_o, wdog_no;

  int n_chk = 0;
  int n_fail = 0;
  int inv_err = 0;

  always #5 clk = ~clk;

  assign mr_n = loop_en ? wdog_no : mr_man;

  sup_reset_ctrl #(.DEBOUNCE_CYC(DB), .HOLD_CYC(HOLD), .WDOG_CYC(WD)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .supply_low_i(supply_low),
    .mr_ni       (mr_n),
    .kick_i      (kick),
    .rst_no      (rst_no),
    .rst_o       (rst_o),
    .wdog_no     (wdog_no)
  );

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (rst_o !== !rst_no) inv_err++;
  endtask

  // ticks until rst_no reaches lvl (bounded)
  task automatic ticks_until_rst(input logic lvl, output int n);
    n = 0;
    while (rst_no !== lvl && n < 500) begin
      tick();
      n++;
    end
  endtask

  task automatic ticks_until_wdog(input logic lvl, output int n);
    n = 0;
    while (wdog_no !== lvl && n < 500) begin
      tick();
      n++;
    end
  endtask

  task automatic t_power_on();
    int n;
    #1;
    chk(rst_no, 0, "R12 rst_no in reset");
    chk(rst_o, 1, "R12 rst_o in reset");
    chk(wdog_no, 1, "R12 wdog_no in reset");
    @(negedge clk);
    rst_ni = 1'b1;
    ticks_until_rst(1'b1, n);
    chk(n, HOLD, "R12 power-on hold length");
    ticks_until_wdog(1'b0, n);
    chk(n, WD + 1, "R8 timeout counted from reset release");
    repeat (10) tick();
    chk(rst_no, 1, "R10 timeout alone keeps reset off");
    chk(wdog_no, 0, "R7 wdog stays low without kick");
  endtask

  task automatic t_kick();
    int lows = 0;
    kick = ~kick;
    repeat (3) tick();
    chk(wdog_no, 0, "R7 wdog low before kick reaches counter");
    tick();
    chk(wdog_no, 1, "R7 wdog recovers after kick");
    for (int i = 0; i < 4 * WD; i++) begin
      if (i % 8 == 0) kick = ~kick;
      tick();
      if (wdog_no !== 1'b1) lows++;
    end
    chk(lows, 0, "R6 periodic kicks keep wdog high");
  endtask

  task automatic t_supply();
    int n;
    int highs = 0;
    kick = ~kick;
    supply_low = 1'b1;
    tick();
    chk(rst_no, 0, "R1 reset on supply low");
    chk(wdog_no, 0, "R9 wdog forced low on supply low");
    for (int i = 0; i < 40; i++) begin
      tick();
      if (rst_no !== 1'b0 || wdog_no !== 1'b0) highs++;
    end
    chk(highs, 0, "R2 outputs held low while supply low");
    supply_low = 1'b0;
    tick();
    chk(wdog_no, 1, "R9 wdog high first cycle after supply ok");
    chk(rst_no, 0, "R3 reset still held after supply ok");
    ticks_until_rst(1'b1, n);
    chk(n + 1, HOLD, "R3 supply release hold length");
  endtask

  task automatic t_retrigger();
    int n;
    int highs = 0;
    kick = ~kick;
    supply_low = 1'b1;
    tick();
    supply_low = 1'b0;
    for (int i = 0; i < HOLD / 2; i++) begin
      tick();
      if (rst_no !== 1'b0) highs++;
    end
    supply_low = 1'b1;
    tick();
    supply_low = 1'b0;
    ticks_until_rst(1'b1, n);
    chk(highs, 0, "R11 reset held before retrigger");
    chk(n, HOLD, "R11 retrigger restarts full hold");
  endtask

  task automatic t_glitch();
    int lows = 0;
    kick = ~kick;
    mr_man = 1'b0;
    repeat (DB - 1) tick();
    mr_man = 1'b1;
    for (int i = 0; i < 15; i++) begin
      tick();
      if (rst_no !== 1'b1) lows++;
    end
    chk(lows, 0, "R4 short manual pulse ignored");
  endtask

  task automatic t_manual();
    int n;
    kick = ~kick;
    mr_man = 1'b0;
    ticks_until_rst(1'b0, n);
    chk(n, 3 + DB, "R1 manual reset latency");
    repeat (5) tick();
    mr_man = 1'b1;
    ticks_until_rst(1'b1, n);
    chk(n, 2 + DB + HOLD, "R3 manual release hold length");
  endtask

  task automatic t_loopback();
    int n;
    loop_en = 1'b1;
    ticks_until_wdog(1'b0, n);
    chk(int'(n < 500), 1, "R10 wdog times out in loopback");
    ticks_until_rst(1'b0, n);
    chk(n, 3 + DB, "R10 looped timeout asserts reset");
    ticks_until_wdog(1'b1, n);
    chk(int'(n < 20), 1, "R8 reset clears watchdog in loopback");
    loop_en = 1'b0;
    ticks_until_rst(1'b1, n);
    chk(rst_no, 1, "R3 reset releases after loop opened");
  endtask

  initial begin : watchdog
    repeat (100_000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_power_on();
    t_kick();
    t_supply();
    t_retrigger();
    t_glitch();
    t_manual();
    t_loopback();
    chk(inv_err, 0, "R5 rst_o inverse of rst_no");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule